// File: doc/BRIEF.md
# Clock Source Switch Controller with Timed Lock Flag

This block picks the active system clock source from a 3-bit request and reports a lock status flag for the sources that pass through the PLL. The flag comes from a counter, not from a phase detector. It starts counting on the first clock after power-on reset when a PLL source is requested, and again on every switch into a PLL source. It sets after a fixed interval and then stays set. It never sees a loss of lock later on, so it can disagree with the real PLL state.

A post-divider on the system clock produces a single-cycle enable pulse at 1/1, 1/2, 1/4 or 1/8 of the reference rate. That pulse is held off while a PLL source is selected and the lock flag is still clear. The block also drives the enable of the secondary low-power oscillator. The enable is set when the configured default source or the requested source is the secondary oscillator, or when any of three timer enable bits asks for it. The analog oscillators, the PLL and the glitch-free clock mux are outside this block.

Top module: `clk_switch_ctrl`

## Requirements
- R1: Source codes are 0 fast RC, 1 fast RC through PLL, 2 primary, 3 primary through PLL, 4 secondary, 5 low-power RC. Codes 6 and 7 act as code 0. `src_sel_o` is one-hot with bit i set for the active code i, and it updates at the first clock edge after `new_src_i` changes.
- R2: While `rst_ni` is low, `src_sel_o` is 6'b000001 and `lock_o`, `clk_en_o` and `sosc_en_o` are 0.
- R3: After an edge that makes a PLL source (code 1 or 3) active, including the first edge after reset, `lock_o` stays 0 for LOCK_CYC-1 further edges and rises at the LOCK_CYC-th edge.
- R4: Once set, `lock_o` stays 1 for as long as the same PLL source remains active.
- R5: A switch from one PLL source to the other clears `lock_o` at the switching edge and restarts the full interval.
- R6: While a non-PLL source is active, `lock_o` is 0 from the switching edge onward.
- R7: `div_sel_i` 00, 01, 10 and 11 give one `clk_en_o` pulse every 1, 2, 4 and 8 reference cycles.
- R8: When `div_sel_i` changes, `clk_en_o` is 0 at that edge, and the first pulse appears at the N-th following edge, where N is the new ratio.
- R9: While a PLL source is active and `lock_o` is 0, `clk_en_o` stays 0.
- R10: `sosc_en_o` is registered, one edge after its inputs. It is 1 when `cfg_src_i` is 4, when `new_src_i` is 4, or when any bit of `tmr_sosc_req_i` is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cfg_src_i | input | 3 | Configured default source code |
| new_src_i | input | 3 | Requested source code |
| div_sel_i | input | 2 | Post-divider ratio code |
| tmr_sosc_req_i | input | 3 | Secondary oscillator requests from three timers |
| src_sel_o | output | 6 | One-hot active source |
| clk_en_o | output | 1 | Divided-clock enable pulse |
| lock_o | output | 1 | Timed PLL lock flag |
| sosc_en_o | output | 1 | Secondary oscillator enable |

## Verification
The source select and the oscillator enable are due one edge after their inputs. The bench drives on the falling edge and samples on the next falling edge. The lock flag is due exactly LOCK_CYC edges after the switching edge, so the bench counts falling edges from the request and checks the flag at LOCK_CYC-1 and at LOCK_CYC. Divider pulses are checked in two ways: by counting them over 64-cycle windows once the ratio has settled, and, after a code change, at each of the first N edges to find where the first pulse lands.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_FRC     = 3'd0,
    SRC_FRC_PLL = 3'd1,
    SRC_PRI     = 3'd2,
    SRC_PRI_PLL = 3'd3,
    SRC_SEC     = 3'd4,
    SRC_LPRC    = 3'd5
  } src_e;

  function automatic src_e norm_src(input logic [SRC_W-1:0] code);
    return (code >= SRC_W'(NUM_SRC)) ? SRC_FRC : src_e'(code);
  endfunction

  function automatic logic uses_pll(input src_e s);
    return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
  endfunction
endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_sw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   req_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               pll_nxt_o,
  output logic               switch_o
);
  src_e               nxt, cur_q;
  logic [NUM_SRC-1:0] sel_d;

  assign nxt       = norm_src(req_i);
  assign pll_nxt_o = uses_pll(nxt);
  assign switch_o  = (nxt != cur_q);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    assign sel_d[i] = (nxt == src_e'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= SRC_FRC;
      sel_o <= NUM_SRC'(1);
    end else begin
      cur_q <= nxt;
      sel_o <= sel_d;
    end
  end

  // R1
  sel_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |=> !$stable(sel_o));
  // R1
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);
endmodule

// File: rtl/clk_lock_timer.sv
module clk_lock_timer #(
  parameter int LOCK_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_nxt_i,
  input  logic switch_i,
  output logic lock_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else if (!pll_nxt_i || switch_i) begin
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else if (!lock_o) begin
      if (cnt_q == LAST) lock_o <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LOCK_CYC));
  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && pll_nxt_i && !switch_i) |=> lock_o);
  // R5
  lock_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_i |=> !lock_o);
  // R6
  lock_nonpll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_nxt_i |=> !lock_o);
endmodule

// File: rtl/clk_post_div.sv
module clk_post_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] code_i,
  input  logic             ok_i,
  output logic             en_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q, last;

  assign last = CNT_W'((1 << code_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      en_o   <= 1'b0;
    end else begin
      code_q <= code_i;
      if (code_i != code_q) begin
        cnt_q <= '0;
        en_o  <= 1'b0;
      end else if (cnt_q == last) begin
        cnt_q <= '0;
        en_o  <= ok_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        en_o  <= 1'b0;
      end
    end
  end

  // R9
  en_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_i |=> !en_o);
  // R8
  en_code_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != code_q) |=> !en_o);
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'((1 << code_q) - 1) || (code_i != code_q));
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clk_sw_pkg::*;
#(
  parameter int LOCK_CYC = 1024,
  parameter int DIV_W    = 2,
  parameter int NUM_TMR  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [SRC_W-1:0]   new_src_i,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic [NUM_TMR-1:0] tmr_sosc_req_i,
  output logic [NUM_SRC-1:0] src_sel_o,
  output logic               clk_en_o,
  output logic               lock_o,
  output logic               sosc_en_o
);
  logic pll_nxt, sw, div_ok;

  clk_src_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (new_src_i),
    .sel_o     (src_sel_o),
    .pll_nxt_o (pll_nxt),
    .switch_o  (sw)
  );

  clk_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pll_nxt_i (pll_nxt),
    .switch_i  (sw),
    .lock_o    (lock_o)
  );

  // pulse only when the source active after this edge is runnable
  assign div_ok = !pll_nxt || (lock_o && !sw);

  clk_post_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (div_sel_i),
    .ok_i   (div_ok),
    .en_o   (clk_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sosc_en_o <= 1'b0;
    else sosc_en_o <= (norm_src(cfg_src_i) == SRC_SEC) ||
                      (norm_src(new_src_i) == SRC_SEC) || (|tmr_sosc_req_i);
  end

  // R10
  sosc_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_sosc_req_i) |=> sosc_en_o);
  // R9
  en_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && (src_sel_o[SRC_FRC_PLL] || src_sel_o[SRC_PRI_PLL])) |-> lock_o);
endmodule

// File: tb/tb_clk_switch_ctrl.sv
module tb_clk_switch_ctrl;
  localparam int LOCK = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cfg_src, new_src, tmr;
  logic [1:0] div_sel;
  logic [5:0] sel;
  logic       en, lock, sosc;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  clk_switch_ctrl #(.LOCK_CYC(LOCK)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_src_i(cfg_src), .new_src_i(new_src),
    .div_sel_i(div_sel), .tmr_sosc_req_i(tmr), .src_sel_o(sel),
    .clk_en_o(en), .lock_o(lock), .sosc_en_o(sosc)
  );

  // {new_src, cfg_src, tmr, expected sel, expected sosc}
  localparam logic [15:0] VEC [9] = '{
    {3'd0, 3'd0, 3'b000, 6'b000001, 1'b0},
    {3'd2, 3'd0, 3'b000, 6'b000100, 1'b0},
    {3'd4, 3'd0, 3'b000, 6'b010000, 1'b1},
    {3'd5, 3'd4, 3'b000, 6'b100000, 1'b1},
    {3'd5, 3'd0, 3'b001, 6'b100000, 1'b1},
    {3'd3, 3'd0, 3'b010, 6'b001000, 1'b1},
    {3'd6, 3'd0, 3'b100, 6'b000001, 1'b1},
    {3'd7, 3'd2, 3'b000, 6'b000001, 1'b0},
    {3'd1, 3'd0, 3'b000, 6'b000010, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (en) c++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    cfg_src = 3'd0; new_src = 3'd0; tmr = 3'b000; div_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 sel", int'(sel), 1);
    chk("R2 lock", int'(lock), 0);
    chk("R2 en", int'(en), 0);
    chk("R2 sosc", int'(sosc), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 / R10 table walk
    for (int v = 0; v < 9; v++) begin
      new_src = VEC[v][15:13];
      cfg_src = VEC[v][12:10];
      tmr     = VEC[v][9:7];
      @(negedge clk);
      chk("R1 sel", int'(sel), int'(VEC[v][6:1]));
      chk("R10 sosc", int'(sosc), int'(VEC[v][0]));
    end

    // R6 leave PLL
    new_src = 3'd0; tmr = 3'b000; cfg_src = 3'd0;
    @(negedge clk);
    chk("R6 lock after leaving pll", int'(lock), 0);

    // R3 / R9 lock interval on fast RC through PLL
    new_src = 3'd1;
    @(negedge clk);
    c = 0;
    for (int k = 1; k <= LOCK; k++) begin
      @(negedge clk);
      if (en) c++;
      if (k == LOCK - 1) chk("R3 lock before interval", int'(lock), 0);
      if (k == LOCK)     chk("R3 lock at interval", int'(lock), 1);
    end
    chk("R9 en while unlocked", c, 0);

    // R4 sticky
    c = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!lock) c++;
    end
    chk("R4 lock sticky", c, 0);

    // R7 ratios while locked
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      repeat (10) @(negedge clk);
      count_en(64, c);
      chk($sformatf("R7 pulses code %0d", d), c, 64 >> d);
    end

    // R8 change to divide-by-8 from divide-by-1
    div_sel = 2'b00;
    repeat (4) @(negedge clk);
    div_sel = 2'b11;
    c = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (en) c++;
    end
    chk("R8 no early pulse", c, 0);
    @(negedge clk);
    chk("R8 first pulse", int'(en), 1);
    div_sel = 2'b00;

    // R5 PLL to PLL switch
    new_src = 3'd3;
    @(negedge clk);
    chk("R5 lock cleared", int'(lock), 0);
    chk("R1 sel pri pll", int'(sel), 8);
    repeat (LOCK - 1) @(negedge clk);
    chk("R5 lock before interval", int'(lock), 0);
    @(negedge clk);
    chk("R5 lock restored", int'(lock), 1);

    // R6 non-PLL stays clear, divider runs
    new_src = 3'd2;
    @(negedge clk);
    c = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (lock) c++;
    end
    chk("R6 lock stays clear", c, 0);
    count_en(16, c);
    chk("R7 divide-by-1 on primary", c, 16);

    // R2 mid-run reset
    new_src = 3'd4;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R2 sel in reset", int'(sel), 1);
    chk("R2 sosc in reset", int'(sosc), 0);
    chk("R2 en in reset", int'(en), 0);
    // R3 count from power-on when PLL requested at release
    new_src = 3'd1;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (LOCK) @(negedge clk);
    chk("R3 lock before interval after reset", int'(lock), 0);
    @(negedge clk);
    chk("R3 lock after reset interval", int'(lock), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule